// File: doc/BRIEF.md
# Per-Scanline Table DMA Engine

This block runs up to eight channels, each of which walks a table in memory once per video frame and pushes a short burst of bytes to a register bus on every scanline. A frame-start strobe loads the first entry of every channel in the enable mask. Each later line strobe serves all channels that are still running, in ascending channel order. A line strobe is the only thing that moves a channel forward.

A table entry starts with a run byte. Bit 7 of the run byte is a repeat flag and bits 6:0 are a line count. In direct mode the burst data follows the run byte inside the table. In indirect mode the run byte is followed by a 16-bit data pointer, low byte first. The channel fetches the next entry on its own when a run ends, and a run byte of zero parks the channel until the next frame start.

While a channel is running, the block masks that channel's pending bit for the general DMA engine. After each strobe it reports the bus cycles the work would have cost.

Top module: `ldma_top`

## Requirements
- R1: After reset the block is idle. It asserts no A-bus read and no register-bus write, and `gdmaPendOut` equals `gdmaPendIn`.
- R2: On `frameInit`, each channel in `enMask` copies its table start into its table pointer and reads the run byte. The channel also reads a 16-bit pointer (low byte, then high byte) when its control bit 6 (indirect) is set. The reported cost is 2 plus 1 per direct channel plus 3 per indirect channel.
- R3: Control bits 2:0 select the burst. Mode 0 is one unit at +0. Mode 1 is +0,+1. Modes 2 and 6 are +0,+0. Modes 3 and 7 are +0,+0,+1,+1. Mode 4 is +0,+1,+2,+3. Mode 5 is +0,+1,+0,+1. Each offset is added to the channel's register base to form `bAddr`, and `bData` is the byte read.
- R4: Burst bytes come from the indirect pointer in indirect mode, or from the table pointer in direct mode (so the data sits right after the run byte). The pointer in use steps by one per unit.
- R5: After each line the run byte is decremented. The channel transfers on the next line only if bit 7 of the new value is set, so a run without the repeat flag transfers on its first line only.
- R6: When bits 6:0 of the decremented run byte are zero, the next entry is loaded at once and the channel transfers on the following line.
- R7: A loaded run byte of zero stops the channel. It makes no reads or writes until the next `frameInit`.
- R8: A line costs 2, plus 1 per running channel, plus 1 per unit moved, plus 2 for each indirect entry reload.
- R9: Channels are served in ascending index order within a line.
- R10: `gdmaPendOut` clears the bits of channels that were enabled at frame start and have not stopped. It passes all other bits of `gdmaPendIn`.
- R11: Every A-bus read carries the channel's bank byte in address bits 23:16. Pointer increments wrap within 16 bits and never carry into the bank.
- R12: `lineDone` pulses for one cycle, in the cycle after `busy` falls, with `lineCost` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameInit | input | 1 | Frame-start strobe |
| lineStrobe | input | 1 | Per-line strobe |
| enMask | input | NCH | Channels enabled at frame start |
| chCtrl | input | NCH*8 | Per-channel control: bits 2:0 mode, bit 6 indirect |
| chBreg | input | NCH*8 | Per-channel register-bus base |
| chTable | input | NCH*16 | Per-channel table start address |
| chBank | input | NCH*8 | Per-channel A-bus bank byte |
| rdEn | output | 1 | A-bus read this cycle |
| rdAddr | output | 24 | A-bus read address |
| rdData | input | 8 | A-bus read data, same cycle |
| bWrEn | output | 1 | Register-bus write strobe |
| bAddr | output | 8 | Register-bus address |
| bData | output | 8 | Register-bus write data |
| gdmaPendIn | input | NCH | General DMA pending bits |
| gdmaPendOut | output | NCH | Pending bits after masking |
| busy | output | 1 | Engine working |
| lineDone | output | 1 | One-cycle completion pulse |
| lineCost | output | COSTW | Cycle cost of the last strobe |

## Verification
The bench builds the block with three channels. This keeps the channel scan short while still covering a disabled channel between two enabled ones, so the ascending service order and the per-channel masking of general DMA pending bits can be observed. Three channels are also enough to run direct and indirect tables, a repeat run followed by an automatic reload and termination, and an indirect pointer that wraps at 0xFFFF inside its bank. Bursts use modes 0, 1, 4 and 5, which give one-, two- and four-unit bursts with distinct offset orders.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

  typedef struct packed {
    logic startFrame;
    logic loadTbl;
    logic latchCnt;
    logic latchLo;
    logic latchHi;
    logic incData;
    logic decCnt;
    logic useData;
  } dpStrb_t;

  function automatic logic [2:0] unitCount(input logic [2:0] mode);
    case (mode)
      3'd0:                      unitCount = 3'd1;
      3'd1, 3'd2, 3'd6:          unitCount = 3'd2;
      default:                   unitCount = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] unitOfs(input logic [2:0] mode, input logic [1:0] u);
    case (mode)
      3'd1, 3'd5: unitOfs = {1'b0, u[0]};
      3'd3, 3'd7: unitOfs = {1'b0, u[1]};
      3'd4:       unitOfs = u;
      default:    unitOfs = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ldma_datapath.sv
module ldma_datapath
  import ldma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [CW-1:0]     sel,
  input  logic [1:0]        bOfs,
  input  logic [NCH-1:0]    enMask,
  input  logic [NCH*8-1:0]  chCtrl,
  input  logic [NCH*8-1:0]  chBreg,
  input  logic [NCH*16-1:0] chTable,
  input  logic [NCH*8-1:0]  chBank,
  input  logic [7:0]        rdData,
  output logic [23:0]       rdAddr,
  output logic [7:0]        bAddr,
  output logic [2:0]        selMode,
  output logic              selIndirect,
  output logic              selFlag,
  output logic              selActive,
  output logic              selLive,
  output logic              reloadHit,
  output logic [NCH-1:0]    liveMask
);

  logic [15:0] tblV [NCH];
  logic [15:0] indV [NCH];
  logic [7:0]  cntV [NCH];
  logic [7:0]  ctrlV [NCH];
  logic [7:0]  bregV [NCH];
  logic [7:0]  bankV [NCH];
  logic [NCH-1:0] flagM, actM, termM;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [15:0] tblPtr, indPtr;
    logic [7:0]  cnt, cntDec;
    logic        flag, act, term;
    logic        isSel, isInd;

    assign isSel  = (sel == CW'(i));
    assign isInd  = chCtrl[i*8+6];
    assign cntDec = cnt - 8'd1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tblPtr <= '0; indPtr <= '0; cnt <= '0;
        flag <= 1'b0; act <= 1'b0; term <= 1'b0;
      end else if (strb.startFrame) begin
        act  <= enMask[i];
        term <= 1'b0;
        flag <= 1'b0;
      end else if (isSel) begin
        if (strb.loadTbl) tblPtr <= chTable[i*16 +: 16];
        if (strb.latchCnt) begin
          cnt    <= rdData;
          flag   <= 1'b1;
          term   <= (rdData == 8'd0);
          tblPtr <= tblPtr + 16'd1;
        end
        if (strb.latchLo) begin
          indPtr[7:0] <= rdData;
          tblPtr      <= tblPtr + 16'd1;
        end
        if (strb.latchHi) begin
          indPtr[15:8] <= rdData;
          tblPtr       <= tblPtr + 16'd1;
        end
        if (strb.incData) begin
          if (isInd) indPtr <= indPtr + 16'd1;
          else       tblPtr <= tblPtr + 16'd1;
        end
        if (strb.decCnt) begin
          cnt  <= cntDec;
          flag <= cntDec[7];
        end
      end
    end

    assign tblV[i]  = tblPtr;
    assign indV[i]  = indPtr;
    assign cntV[i]  = cnt;
    assign ctrlV[i] = chCtrl[i*8 +: 8];
    assign bregV[i] = chBreg[i*8 +: 8];
    assign bankV[i] = chBank[i*8 +: 8];
    assign flagM[i] = flag;
    assign actM[i]  = act;
    assign termM[i] = term;
  end

  logic [7:0] selCntDec;

  assign selMode     = ctrlV[sel][2:0];
  assign selIndirect = ctrlV[sel][6];
  assign selFlag     = flagM[sel];
  assign selActive   = actM[sel];
  assign selLive     = actM[sel] & ~termM[sel];
  assign selCntDec   = cntV[sel] - 8'd1;
  assign reloadHit   = (selCntDec[6:0] == 7'd0);
  assign liveMask    = actM & ~termM;
  assign rdAddr      = {bankV[sel], (strb.useData && selIndirect) ? indV[sel] : tblV[sel]};
  assign bAddr       = bregV[sel] + {6'd0, bOfs};

endmodule

// File: rtl/ldma_ctrl.sv
module ldma_ctrl
  import ldma_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CW    = 3,
  parameter int COSTW = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameInit,
  input  logic             lineStrobe,
  input  logic [2:0]       selMode,
  input  logic             selIndirect,
  input  logic             selFlag,
  input  logic             selActive,
  input  logic             selLive,
  input  logic             reloadHit,
  output dpStrb_t          strb,
  output logic [CW-1:0]    sel,
  output logic [1:0]       bOfs,
  output logic             rdEn,
  output logic             bWrEn,
  output logic             busy,
  output logic             lineDone,
  output logic [COSTW-1:0] lineCost
);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_LDCNT, S_LDLO, S_LDHI, S_XFER, S_DEC, S_FIN} st_t;

  st_t              state;
  logic             inLine, reload;
  logic [1:0]       unit;
  logic [COSTW-1:0] cost;
  logic             lastCh, hit, lastUnit;

  assign lastCh   = (sel == CW'(NCH - 1));
  assign hit      = inLine ? selLive : selActive;
  assign lastUnit = ({1'b0, unit} == unitCount(selMode) - 3'd1);
  assign busy     = (state != S_IDLE);
  assign bOfs     = unitOfs(selMode, unit);

  always_comb begin
    strb  = '0;
    rdEn  = 1'b0;
    bWrEn = 1'b0;
    case (state)
      S_IDLE:  strb.startFrame = frameInit;
      S_SCAN:  strb.loadTbl = hit && !inLine;
      S_LDCNT: begin rdEn = 1'b1; strb.latchCnt = 1'b1; end
      S_LDLO:  begin rdEn = 1'b1; strb.latchLo = 1'b1; end
      S_LDHI:  begin rdEn = 1'b1; strb.latchHi = 1'b1; end
      S_XFER:  begin rdEn = 1'b1; bWrEn = 1'b1; strb.incData = 1'b1; strb.useData = 1'b1; end
      S_DEC:   strb.decCnt = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; inLine <= 1'b0; reload <= 1'b0; unit <= '0;
      cost <= '0; sel <= '0; lineDone <= 1'b0; lineCost <= '0;
    end else begin
      lineDone <= 1'b0;
      case (state)
        S_IDLE: if (frameInit || lineStrobe) begin
          inLine <= !frameInit;
          reload <= 1'b0;
          sel    <= '0;
          cost   <= COSTW'(2);
          state  <= S_SCAN;
        end
        S_SCAN: if (hit) begin
          if (inLine) begin
            cost  <= cost + COSTW'(1);
            unit  <= '0;
            state <= selFlag ? S_XFER : S_DEC;
          end else state <= S_LDCNT;
        end else if (lastCh) state <= S_FIN;
        else sel <= sel + CW'(1);
        S_LDCNT: begin
          if (!reload) cost <= cost + COSTW'(1);
          if (selIndirect) state <= S_LDLO;
          else begin
            reload <= 1'b0;
            if (lastCh) state <= S_FIN;
            else begin sel <= sel + CW'(1); state <= S_SCAN; end
          end
        end
        S_LDLO: begin cost <= cost + COSTW'(1); state <= S_LDHI; end
        S_LDHI: begin
          cost   <= cost + COSTW'(1);
          reload <= 1'b0;
          if (lastCh) state <= S_FIN;
          else begin sel <= sel + CW'(1); state <= S_SCAN; end
        end
        S_XFER: begin
          cost <= cost + COSTW'(1);
          unit <= unit + 2'd1;
          if (lastUnit) state <= S_DEC;
        end
        S_DEC: begin
          if (reloadHit) begin reload <= 1'b1; state <= S_LDCNT; end
          else if (lastCh) state <= S_FIN;
          else begin sel <= sel + CW'(1); state <= S_SCAN; end
        end
        S_FIN: begin
          lineDone <= 1'b1;
          lineCost <= cost;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ldma_top.sv
module ldma_top
  import ldma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int COSTW = $clog2(2 + NCH * 7 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameInit,
  input  logic              lineStrobe,
  input  logic [NCH-1:0]    enMask,
  input  logic [NCH*8-1:0]  chCtrl,
  input  logic [NCH*8-1:0]  chBreg,
  input  logic [NCH*16-1:0] chTable,
  input  logic [NCH*8-1:0]  chBank,
  output logic              rdEn,
  output logic [23:0]       rdAddr,
  input  logic [7:0]        rdData,
  output logic              bWrEn,
  output logic [7:0]        bAddr,
  output logic [7:0]        bData,
  input  logic [NCH-1:0]    gdmaPendIn,
  output logic [NCH-1:0]    gdmaPendOut,
  output logic              busy,
  output logic              lineDone,
  output logic [COSTW-1:0]  lineCost
);

  dpStrb_t        strb;
  logic [CW-1:0]  sel;
  logic [1:0]     bOfs;
  logic [2:0]     selMode;
  logic           selIndirect, selFlag, selActive, selLive, reloadHit;
  logic [NCH-1:0] liveMask;

  ldma_ctrl #(.NCH(NCH), .CW(CW), .COSTW(COSTW)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameInit(frameInit), .lineStrobe(lineStrobe),
    .selMode(selMode), .selIndirect(selIndirect), .selFlag(selFlag),
    .selActive(selActive), .selLive(selLive), .reloadHit(reloadHit),
    .strb(strb), .sel(sel), .bOfs(bOfs), .rdEn(rdEn), .bWrEn(bWrEn),
    .busy(busy), .lineDone(lineDone), .lineCost(lineCost)
  );

  ldma_datapath #(.NCH(NCH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sel(sel), .bOfs(bOfs),
    .enMask(enMask), .chCtrl(chCtrl), .chBreg(chBreg), .chTable(chTable),
    .chBank(chBank), .rdData(rdData), .rdAddr(rdAddr), .bAddr(bAddr),
    .selMode(selMode), .selIndirect(selIndirect), .selFlag(selFlag),
    .selActive(selActive), .selLive(selLive), .reloadHit(reloadHit),
    .liveMask(liveMask)
  );

  assign bData       = rdData;
  assign gdmaPendOut = gdmaPendIn & ~liveMask;

endmodule

// File: rtl/ldma_chk.sv
module ldma_chk #(
  parameter int NCH   = 8,
  parameter int COSTW = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameInit,
  input logic             rdEn,
  input logic             bWrEn,
  input logic [NCH-1:0]   gdmaPendIn,
  input logic [NCH-1:0]   gdmaPendOut,
  input logic             busy,
  input logic             lineDone
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdEn && !bWrEn));

  // R3
  write_has_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    bWrEn |-> rdEn);

  // R10
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gdmaPendOut & ~gdmaPendIn) == '0);

  // R2
  init_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameInit && !busy) |=> busy);

  // R12
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> lineDone);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);

endmodule

bind ldma_top ldma_chk #(.NCH(NCH), .COSTW(COSTW)) u_chk (
  .clk(clk), .rstN(rstN), .frameInit(frameInit), .rdEn(rdEn), .bWrEn(bWrEn),
  .gdmaPendIn(gdmaPendIn), .gdmaPendOut(gdmaPendOut), .busy(busy),
  .lineDone(lineDone)
);

// File: tb/ldma_top_bench.sv
module ldma_top_bench;
  localparam int NCH = 3;
  localparam int COSTW = $clog2(2 + NCH * 7 + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameInit = 1'b0, lineStrobe = 1'b0;
  logic [NCH-1:0] enMask = '0, gdmaPendIn = '0;
  logic [NCH*8-1:0] chCtrl = '0, chBreg = '0, chBank = '0;
  logic [NCH*16-1:0] chTable = '0;
  logic rdEn, bWrEn, busy, lineDone;
  logic [23:0] rdAddr;
  logic [7:0] rdData, bAddr, bData;
  logic [NCH-1:0] gdmaPendOut;
  logic [COSTW-1:0] lineCost;

  logic [7:0] mem [1024];
  assign rdData = mem[rdAddr[9:0]];

  always #4 clk = ~clk;

  ldma_top #(.NCH(NCH)) u_ldma_top (.*);

  int tests = 0, fails = 0;
  int logN = 0, bankErr = 0, cycles = 0;
  logic [7:0] logA [32];
  logic [7:0] logD [32];
  logic [7:0] expBank = 8'h00;
  int lastCost = 0;

  always @(negedge clk) if (rstN) begin
    if (bWrEn && logN < 32) begin logA[logN] = bAddr; logD[logN] = bData; logN++; end
    if (rdEn && rdAddr[23:16] != expBank) bankErr++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic strobe(input bit isFrame);
    @(negedge clk);
    if (isFrame) frameInit = 1'b1; else lineStrobe = 1'b1;
    @(negedge clk);
    frameInit = 1'b0; lineStrobe = 1'b0;
    while (!lineDone) @(negedge clk);
    lastCost = int'(lineCost);
  endtask

  task automatic expectWrites(input string req, input int n, input logic [7:0] a [4], input logic [7:0] d [4]);
    chk(logN == n, req, logN, n);
    for (int k = 0; k < n && k < logN; k++) begin
      chk(logA[k] == a[k], req, logA[k], a[k]);
      chk(logD[k] == d[k], req, logD[k], d[k]);
    end
    logN = 0;
  endtask

  task automatic tReset();
    gdmaPendIn = 3'b101;
    @(negedge clk);
    chk(!busy && !rdEn && !bWrEn, "R1", busy, 0);
    chk(gdmaPendOut == 3'b101, "R1", gdmaPendOut, 3'b101);
  endtask

  task automatic tDirectRepeat();
    logic [7:0] a [4];
    logic [7:0] d [4];
    mem[16'h100] = 8'h02; mem[16'h101] = 8'hA0; mem[16'h102] = 8'hA1;
    mem[16'h103] = 8'h82; mem[16'h104] = 8'hB0; mem[16'h105] = 8'hB1;
    mem[16'h106] = 8'hB2; mem[16'h107] = 8'hB3; mem[16'h108] = 8'h00;
    chCtrl[7:0] = 8'h01; chBreg[7:0] = 8'h18; chTable[15:0] = 16'h0100; chBank[7:0] = 8'h00;
    expBank = 8'h00; enMask = 3'b001; gdmaPendIn = 3'b111; logN = 0; bankErr = 0;
    strobe(1);
    chk(lastCost == 3, "R2", lastCost, 3);
    chk(gdmaPendOut == 3'b110, "R10", gdmaPendOut, 3'b110);
    strobe(0);
    a = '{8'h18, 8'h19, 0, 0}; d = '{8'hA0, 8'hA1, 0, 0};
    expectWrites("R3 R4", 2, a, d);
    chk(lastCost == 5, "R8", lastCost, 5);
    strobe(0);
    expectWrites("R5", 0, a, d);
    chk(lastCost == 3, "R6", lastCost, 3);
    strobe(0);
    a = '{8'h18, 8'h19, 0, 0}; d = '{8'hB0, 8'hB1, 0, 0};
    expectWrites("R6", 2, a, d);
    strobe(0);
    a = '{8'h18, 8'h19, 0, 0}; d = '{8'hB2, 8'hB3, 0, 0};
    expectWrites("R5 repeat", 2, a, d);
    chk(lastCost == 5, "R8", lastCost, 5);
    strobe(0);
    expectWrites("R7", 0, a, d);
    chk(lastCost == 2, "R7", lastCost, 2);
    chk(gdmaPendOut == 3'b111, "R10", gdmaPendOut, 3'b111);
    chk(bankErr == 0, "R11", bankErr, 0);
  endtask

  task automatic tIndirect();
    logic [7:0] a [4];
    logic [7:0] d [4];
    mem[16'h200] = 8'h01; mem[16'h201] = 8'h80; mem[16'h202] = 8'h03; mem[16'h203] = 8'h00;
    mem[16'h380] = 8'h11; mem[16'h381] = 8'h22; mem[16'h382] = 8'h33; mem[16'h383] = 8'h44;
    chCtrl[15:8] = 8'h44; chBreg[15:8] = 8'h40; chTable[31:16] = 16'h0200; chBank[15:8] = 8'h12;
    expBank = 8'h12; enMask = 3'b010; logN = 0; bankErr = 0;
    strobe(1);
    chk(lastCost == 5, "R2", lastCost, 5);
    strobe(0);
    a = '{8'h40, 8'h41, 8'h42, 8'h43}; d = '{8'h11, 8'h22, 8'h33, 8'h44};
    expectWrites("R3 R4", 4, a, d);
    chk(lastCost == 9, "R8", lastCost, 9);
    strobe(0);
    expectWrites("R7", 0, a, d);
    chk(bankErr == 0, "R11", bankErr, 0);
  endtask

  task automatic tOrder();
    logic [7:0] a [4];
    logic [7:0] d [4];
    mem[16'h300] = 8'h01; mem[16'h301] = 8'hC5; mem[16'h302] = 8'h00;
    mem[16'h310] = 8'h01; mem[16'h311] = 8'hD7; mem[16'h312] = 8'hD8;
    mem[16'h313] = 8'hD9; mem[16'h314] = 8'hDA; mem[16'h315] = 8'h00;
    chCtrl = {8'h05, 8'h44, 8'h00}; chBreg = {8'h33, 8'h40, 8'h22};
    chTable = {16'h0310, 16'h0200, 16'h0300}; chBank = '0;
    expBank = 8'h00; enMask = 3'b101; gdmaPendIn = 3'b111; logN = 0; bankErr = 0;
    strobe(1);
    chk(lastCost == 4, "R2", lastCost, 4);
    chk(gdmaPendOut == 3'b010, "R10", gdmaPendOut, 3'b010);
    strobe(0);
    chk(logN == 5, "R9", logN, 5);
    chk(logA[0] == 8'h22 && logD[0] == 8'hC5, "R9", logD[0], 8'hC5);
    a = '{8'h33, 8'h34, 8'h33, 8'h34}; d = '{8'hD7, 8'hD8, 8'hD9, 8'hDA};
    for (int k = 0; k < 4; k++) begin
      chk(logA[k+1] == a[k], "R3 mode5", logA[k+1], a[k]);
      chk(logD[k+1] == d[k], "R3 mode5", logD[k+1], d[k]);
    end
    logN = 0;
    chk(lastCost == 9, "R8", lastCost, 9);
    chk(gdmaPendOut == 3'b111, "R10", gdmaPendOut, 3'b111);
  endtask

  task automatic tWrap();
    logic [7:0] a [4];
    logic [7:0] d [4];
    mem[16'h020] = 8'h01; mem[16'h021] = 8'hFF; mem[16'h022] = 8'hFF; mem[16'h023] = 8'h00;
    mem[10'h3FF] = 8'h5A; mem[10'h000] = 8'h6B;
    chCtrl = {8'h00, 8'h00, 8'h41}; chBreg = {8'h00, 8'h00, 8'h50};
    chTable = {16'h0, 16'h0, 16'h0020}; chBank = {8'h00, 8'h00, 8'h05};
    expBank = 8'h05; enMask = 3'b001; logN = 0; bankErr = 0;
    strobe(1);
    strobe(0);
    a = '{8'h50, 8'h51, 0, 0}; d = '{8'h5A, 8'h6B, 0, 0};
    expectWrites("R11", 2, a, d);
    chk(bankErr == 0, "R11", bankErr, 0);
    chk(lastCost == 7, "R8", lastCost, 7);
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tDirectRepeat();
    tIndirect();
    tOrder();
    tWrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule